// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the byte addresses for one DMA channel while it moves a block of elements arranged in frames. A pulse on `start` latches the start addresses, the four 16-bit index values, the index-sharing bit, the two stepping modes, the element width and the element and frame counts. After that, the block emits one byte address per cycle. Each element is first read byte by byte at the source address and then written byte by byte at the destination address.

Each address register finishes an element pointing at that element's last byte. The index is added from that point, so the distance from one element start to the next is the index plus the element size minus one. Each side has its own stepping mode:

- **Constant:** the side keeps its start address for every element.
- **Single-index:** the side adds its element index after every element.
- **Double-index:** the side adds its element index, except after the last element of a frame, where it adds the frame index.

With the sharing bit clear, both sides take their indexes from the source index inputs. With it set, each side uses its own pair. A start address that does not match the element width sets a sticky error flag, and address generation carries on.

Top module: `dma_addr_gen`

## Requirements
- R1: During and after reset, `acc_valid`, `done` and `misalign` are 0. The latched index-sharing bit and the other latched settings reset to 0.
- R2: `dtype` sets the bytes per element: 2'b00 is 1 byte, 2'b01 is 2 bytes, and 2'b10 or 2'b11 is 4 bytes. One access is issued per cycle. For each element, the source bytes come first at consecutive rising addresses (`addr_is_dst`=0), then the destination bytes in the same way (`addr_is_dst`=1).
- R3: Mode 2'b01 (single-index): the start of the next element on that side equals the element's last-byte address plus the sign-extended element index.
- R4: Mode 2'b10 (double-index): the element index is added as in R3, except after the last element of a frame, where the frame index is added instead.
- R5: Mode 2'b00 (and 2'b11) is constant: every element on that side starts at the side's start address.
- R6: With `idx_shared_n`=0, the destination side uses `src_eidx` and `src_fidx`. The `dst_eidx` and `dst_fidx` inputs then have no effect on any address.
- R7: With `idx_shared_n`=1, the source side uses only the source indexes and the destination side uses only the destination indexes.
- R8: Indexes are 16-bit two's-complement values, sign-extended to the address width. Address arithmetic wraps modulo 2^AW.
- R9: A job covers `frame_cnt` frames of `elem_cnt` elements each. A count of 0 acts as 1.
- R10: `done` is high for exactly one cycle: the cycle right after the last destination byte of the last element of the last frame. `acc_valid` is 0 in that cycle.
- R11: `misalign` is set when an element starts at an address that is not a multiple of its byte size on either side. It stays set until the next accepted start and does not stop or change address generation.
- R12: A `start` pulse while accesses are in progress is ignored. The running job's addresses are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; accepted only when idle |
| idx_shared_n | input | 1 | 0: both sides use source indexes; 1: separate indexes |
| src_mode | input | 2 | Source stepping mode (00 const, 01 single, 10 double) |
| dst_mode | input | 2 | Destination stepping mode |
| dtype | input | 2 | Element width code |
| src_start | input | AW | Source start byte address |
| dst_start | input | AW | Destination start byte address |
| src_eidx | input | 16 | Source element index |
| src_fidx | input | 16 | Source frame index |
| dst_eidx | input | 16 | Destination element index |
| dst_fidx | input | 16 | Destination frame index |
| elem_cnt | input | CW | Elements per frame |
| frame_cnt | input | CW | Frames per job |
| acc_valid | output | 1 | A byte access is issued this cycle |
| addr_is_dst | output | 1 | Access is on the destination side |
| addr | output | AW | Current byte address |
| done | output | 1 | One-cycle end-of-job pulse |
| misalign | output | 1 | Sticky element-alignment error |

## Verification
The checker watches four properties on every cycle:

- Bytes on the same side in consecutive cycles have addresses that rise by one.
- `done` lasts a single cycle, always follows an access cycle and never overlaps one.
- An accepted start produces an access on the next cycle.
- `misalign` only clears on an accepted start.

The index arithmetic cannot be seen from one cycle to the next. This covers the last-byte-plus-index stepping, the frame index in double mode, sharing versus independent indexes, sign extension, wrap and the element and frame counts. The bench's scoreboard scenarios cover it by comparing every emitted address against an independently computed list. They also cover ignored restarts and the alignment flag's value for each job.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    typedef enum logic [1:0] {
        STEP_CONST  = 2'b00,
        STEP_SINGLE = 2'b01,
        STEP_DOUBLE = 2'b10,
        STEP_HOLD   = 2'b11
    } step_mode_e;

    // Offset of the last byte of an element from its first byte.
    function automatic logic [1:0] last_off(input logic [1:0] dt);
        case (dt)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/dma_ag_step.sv
module dma_ag_step
    import dma_ag_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    dtype,
    input  logic [1:0]    mode,
    input  logic [IW-1:0] eidx,
    input  logic [IW-1:0] fidx,
    input  logic          frame_end,
    output logic [AW-1:0] next_base
);
    localparam int EXT = AW - IW;

    logic [AW-1:0] last_byte;
    logic [AW-1:0] e_ext;
    logic [AW-1:0] f_ext;

    always_comb begin
        last_byte = base + AW'(last_off(dtype));
        e_ext     = {{EXT{eidx[IW-1]}}, eidx};
        f_ext     = {{EXT{fidx[IW-1]}}, fidx};
        case (step_mode_e'(mode))
            STEP_SINGLE: next_base = last_byte + e_ext;
            STEP_DOUBLE: next_base = last_byte + (frame_end ? f_ext : e_ext);
            default:     next_base = base;
        endcase
    end
endmodule

// File: rtl/dma_ag_align.sv
module dma_ag_align
    import dma_ag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    dtype,
    output logic          bad
);
    always_comb begin
        case (dtype)
            2'b00:   bad = 1'b0;
            2'b01:   bad = base[0];
            default: bad = |base[1:0];
        endcase
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          idx_shared_n,
    input  logic [1:0]    src_mode,
    input  logic [1:0]    dst_mode,
    input  logic [1:0]    dtype,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic [15:0]   src_eidx,
    input  logic [15:0]   src_fidx,
    input  logic [15:0]   dst_eidx,
    input  logic [15:0]   dst_fidx,
    input  logic [CW-1:0] elem_cnt,
    input  logic [CW-1:0] frame_cnt,
    output logic          acc_valid,
    output logic          addr_is_dst,
    output logic [AW-1:0] addr,
    output logic          done,
    output logic          misalign
);
    localparam int IW    = 16;
    localparam int SIDES = 2;

    typedef struct packed {
        logic                      busy;
        logic                      side;
        logic [1:0]                bidx;
        logic [SIDES-1:0][AW-1:0]  base;
        logic [CW-1:0]             elem_left;
        logic [CW-1:0]             elem_cfg;
        logic [CW-1:0]             frame_left;
        logic                      done;
        logic                      mis;
        logic                      shared_n;
        logic [1:0]                dtype;
        logic [SIDES-1:0][1:0]     mode;
        logic [SIDES-1:0][IW-1:0]  eidx;
        logic [SIDES-1:0][IW-1:0]  fidx;
    } state_t;

    state_t q, d;

    logic [SIDES-1:0][AW-1:0] nxt;
    logic [SIDES-1:0]         bad;
    logic                     frame_end;

    assign frame_end = (q.elem_left == CW'(1));

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dma_ag_step #(.AW(AW), .IW(IW)) u_step (
            .base      (q.base[s]),
            .dtype     (q.dtype),
            .mode      (q.mode[s]),
            .eidx      (q.eidx[s]),
            .fidx      (q.fidx[s]),
            .frame_end (frame_end),
            .next_base (nxt[s])
        );
        dma_ag_align #(.AW(AW)) u_align (
            .base  (q.base[s]),
            .dtype (q.dtype),
            .bad   (bad[s])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy       = 1'b1;
                d.side       = 1'b0;
                d.bidx       = 2'd0;
                d.mis        = 1'b0;
                d.shared_n   = idx_shared_n;
                d.dtype      = dtype;
                d.base[0]    = src_start;
                d.base[1]    = dst_start;
                d.mode[0]    = src_mode;
                d.mode[1]    = dst_mode;
                d.eidx[0]    = src_eidx;
                d.fidx[0]    = src_fidx;
                d.eidx[1]    = idx_shared_n ? dst_eidx : src_eidx;
                d.fidx[1]    = idx_shared_n ? dst_fidx : src_fidx;
                d.elem_cfg   = (elem_cnt  == '0) ? CW'(1) : elem_cnt;
                d.elem_left  = (elem_cnt  == '0) ? CW'(1) : elem_cnt;
                d.frame_left = (frame_cnt == '0) ? CW'(1) : frame_cnt;
            end
        end else begin
            if (q.bidx == 2'd0 && bad[q.side]) begin
                d.mis = 1'b1;
            end
            if (q.bidx == last_off(q.dtype)) begin
                d.bidx         = 2'd0;
                d.base[q.side] = nxt[q.side];
                if (!q.side) begin
                    d.side = 1'b1;
                end else begin
                    d.side = 1'b0;
                    if (frame_end) begin
                        d.elem_left = q.elem_cfg;
                        if (q.frame_left == CW'(1)) begin
                            d.busy = 1'b0;
                            d.done = 1'b1;
                        end else begin
                            d.frame_left = q.frame_left - CW'(1);
                        end
                    end else begin
                        d.elem_left = q.elem_left - CW'(1);
                    end
                end
            end else begin
                d.bidx = q.bidx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_valid   = q.busy;
    assign addr_is_dst = q.side;
    assign addr        = q.base[q.side] + AW'(q.bidx);
    assign done        = q.done;
    assign misalign    = q.mis;

endmodule

// File: rtl/dma_ag_chk.sv
module dma_ag_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          acc_valid,
    input logic          addr_is_dst,
    input logic [AW-1:0] addr,
    input logic          done,
    input logic          misalign
);
    // R2
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid) && (addr_is_dst == $past(addr_is_dst)))
        |-> (addr == $past(addr) + AW'(1)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!acc_valid && $past(acc_valid)));

    // R11
    mis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign && !(start && !acc_valid)) |=> misalign);

    // R12
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !acc_valid) |=> acc_valid);
endmodule

bind dma_addr_gen dma_ag_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .acc_valid   (acc_valid),
    .addr_is_dst (addr_is_dst),
    .addr        (addr),
    .done        (done),
    .misalign    (misalign)
);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          idx_shared_n = 1'b0;
    logic [1:0]    src_mode = '0, dst_mode = '0, dtype = '0;
    logic [AW-1:0] src_start = '0, dst_start = '0;
    logic [15:0]   src_eidx = '0, src_fidx = '0, dst_eidx = '0, dst_fidx = '0;
    logic [CW-1:0] elem_cnt = '0, frame_cnt = '0;
    logic          acc_valid, addr_is_dst, done, misalign;
    logic [AW-1:0] addr;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R2";
    logic [AW:0] expq[$];

    always #4 clk = ~clk;

    dma_addr_gen #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_shared_n(idx_shared_n),
        .src_mode(src_mode), .dst_mode(dst_mode), .dtype(dtype),
        .src_start(src_start), .dst_start(dst_start),
        .src_eidx(src_eidx), .src_fidx(src_fidx),
        .dst_eidx(dst_eidx), .dst_fidx(dst_fidx),
        .elem_cnt(elem_cnt), .frame_cnt(frame_cnt),
        .acc_valid(acc_valid), .addr_is_dst(addr_is_dst), .addr(addr),
        .done(done), .misalign(misalign)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected accesses and compares.
    always @(negedge clk) begin
        if (rst_n && acc_valid) begin
            if (expq.size() == 0) begin
                check({cur_tag, " extra access"}, {31'd0, addr_is_dst, addr}, 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                logic [AW:0] e;
                e = expq.pop_front();
                check({cur_tag, " access"}, {31'd0, addr_is_dst, addr}, {31'd0, e});
            end
        end
    end

    function automatic logic [AW-1:0] sx(input logic [15:0] v);
        return {{(AW-16){v[15]}}, v};
    endfunction

    task automatic model_step(inout logic [AW-1:0] b, input int n, input logic [1:0] m,
                              input logic [15:0] e, input logic [15:0] f, input bit fend);
        logic [AW-1:0] last;
        last = b + AW'(n - 1);
        if (m == 2'b01)      b = last + sx(e);
        else if (m == 2'b10) b = last + (fend ? sx(f) : sx(e));
    endtask

    function automatic bit unaligned(input logic [AW-1:0] b, input int n);
        if (n == 2) return b[0];
        if (n == 4) return |b[1:0];
        return 1'b0;
    endfunction

    task automatic run_job(input string tag, input logic sh, input logic [1:0] sm, input logic [1:0] dm,
                           input logic [1:0] dt, input logic [AW-1:0] ss, input logic [AW-1:0] ds,
                           input logic [15:0] se, input logic [15:0] sf,
                           input logic [15:0] de, input logic [15:0] df,
                           input int ec, input int fc, input bit restart);
        int n, ee, ff, wait_cnt;
        logic [AW-1:0] sb, db;
        logic [15:0] ue, uf;
        bit exp_mis;
        n = (dt == 2'b00) ? 1 : (dt == 2'b01) ? 2 : 4;
        ee = (ec == 0) ? 1 : ec;
        ff = (fc == 0) ? 1 : fc;
        ue = sh ? de : se;
        uf = sh ? df : sf;
        sb = ss; db = ds; exp_mis = 1'b0;
        cur_tag = tag;
        for (int fr = 0; fr < ff; fr++) begin
            for (int el = 0; el < ee; el++) begin
                if (unaligned(sb, n) || unaligned(db, n)) exp_mis = 1'b1;
                for (int k = 0; k < n; k++) expq.push_back({1'b0, sb + AW'(k)});
                for (int k = 0; k < n; k++) expq.push_back({1'b1, db + AW'(k)});
                model_step(sb, n, sm, se, sf, el == ee - 1);
                model_step(db, n, dm, ue, uf, el == ee - 1);
            end
        end
        @(negedge clk);
        idx_shared_n = sh; src_mode = sm; dst_mode = dm; dtype = dt;
        src_start = ss; dst_start = ds; src_eidx = se; src_fidx = sf;
        dst_eidx = de; dst_fidx = df; elem_cnt = CW'(ec); frame_cnt = CW'(fc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            @(negedge clk);
            src_start = 32'h0000_5550; dst_start = 32'h0000_6660;
            src_mode = 2'b01; elem_cnt = 16'd9;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cnt = 0;
        while (done !== 1'b1 && wait_cnt < 5000) begin
            @(negedge clk);
            wait_cnt++;
        end
        check({tag, " R10 done seen"}, {63'd0, done}, 64'd1);
        check({tag, " R10 queue drained at done"}, 64'(expq.size()), 64'd0);
        check({tag, " R10 no access with done"}, {63'd0, acc_valid}, 64'd0);
        check({tag, " R11 misalign flag"}, {63'd0, misalign}, {63'd0, exp_mis});
        @(negedge clk);
        check({tag, " R10 done one cycle"}, {63'd0, done}, 64'd0);
        expq.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 acc_valid", {63'd0, acc_valid}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 misalign", {63'd0, misalign}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {63'd0, acc_valid}, 64'd0);

        // R2 bytes, shared indexes, contiguous
        run_job("R2", 1'b0, 2'b01, 2'b01, 2'b00, 32'h100, 32'h200,
                16'h1, 16'h0, 16'h0, 16'h0, 4, 1, 1'b0);
        // R3 and R7: word elements, independent indexes
        run_job("R3 R7", 1'b1, 2'b01, 2'b01, 2'b10, 32'h2000, 32'h3000,
                16'h1, 16'h0, 16'h5, 16'h0, 3, 1, 1'b0);
        // R4 double-index, halfword last-of-frame at 0x801E, frame index 3
        run_job("R4", 1'b1, 2'b10, 2'b00, 2'b01, 32'h801E, 32'h9000,
                16'h1, 16'h3, 16'h0, 16'h0, 1, 2, 1'b0);
        // R4 double-index with several elements per frame
        run_job("R4 multi", 1'b1, 2'b10, 2'b10, 2'b01, 32'h400, 32'h800,
                16'h3, 16'h11, 16'h1, 16'hFFF1, 3, 2, 1'b0);
        // R5 constant mode
        run_job("R5", 1'b1, 2'b00, 2'b11, 2'b10, 32'h40, 32'h80,
                16'h9, 16'h9, 16'h9, 16'h9, 3, 2, 1'b0);
        // R6 shared: dst index inputs carry junk and must have no effect
        run_job("R6", 1'b0, 2'b01, 2'b10, 2'b00, 32'h500, 32'h600,
                16'h3, 16'hFFFB, 16'h7777, 16'h7777, 2, 2, 1'b0);
        // R8 wrap and negative index
        run_job("R8", 1'b1, 2'b01, 2'b01, 2'b01, 32'hFFFF_FFFE, 32'h0000_1000,
                16'h1, 16'h0, 16'hFFF9, 16'h0, 3, 1, 1'b0);
        // R9 zero counts act as one
        run_job("R9", 1'b1, 2'b01, 2'b01, 2'b01, 32'h700, 32'h720,
                16'h1, 16'h0, 16'h1, 16'h0, 0, 0, 1'b0);
        // R9 multiple frames
        run_job("R9 frames", 1'b1, 2'b10, 2'b01, 2'b00, 32'hA00, 32'hB00,
                16'h2, 16'h10, 16'h4, 16'h0, 2, 3, 1'b0);
        // R11 misaligned word start, generation continues
        run_job("R11 set", 1'b1, 2'b01, 2'b01, 2'b10, 32'h1002, 32'h2000,
                16'h1, 16'h0, 16'h1, 16'h0, 2, 1, 1'b0);
        // R11 flag cleared by next accepted start
        run_job("R11 clear", 1'b1, 2'b01, 2'b01, 2'b10, 32'h1000, 32'h2000,
                16'h1, 16'h0, 16'h1, 16'h0, 2, 1, 1'b0);
        // R12 start pulse during a running job is ignored
        run_job("R12", 1'b1, 2'b01, 2'b00, 2'b01, 32'hC00, 32'hD00,
                16'h1, 16'h0, 16'h0, 16'h0, 3, 1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule